// File: doc/BRIEF.md
# Dual-Edge PDM Microphone Capture

This block derives a pulse-density-modulation bit clock from a master audio clock and captures one-bit samples from up to four digital microphones. The microphones share two data wires in pairs. On each wire, one microphone drives its bit while the bit clock is high and the other drives while it is low. A two-bit divider code sets the bit-clock rate. With a 24.576 MHz master clock this gives 6.144, 3.072, 1.536 or 0.768 MHz, and with 22.5792 MHz it gives 5.6448, 2.8224, 1.4112 or 0.7056 MHz.

A control bit for each channel picks whether that channel takes the value held during the high half or the low half of the bit clock. Each value is sampled in the last master cycle before the opposite clock edge, where the bit is settled. Once in every bit-clock period, the four channel bits are presented together with a one-cycle valid strobe, ready for a downstream decimator. Channels 1 and 2 also have a source code. It chooses either the digital capture or a placeholder analog bit input, and an analog power-down flag is raised whenever the digital source is chosen.

The clock generator is a state machine with three states. `GEN_IDLE` is the reset state. `GEN_HIGH` is the high half of the bit clock and `GEN_LOW` is the low half. The transitions are:
- idle-to-high: on the first master edge after reset, which also loads the divider code.
- high-to-low: when the half-period counter reaches its last count.
- low-to-high: at the end of the low half, which also reloads the divider code.

Top module: `pdm_mic_capture`

## Requirements
- R1: `div_sel` codes 0, 1, 2 and 3 give a bit clock whose high and low halves each last 2, 4, 8 and 16 master cycles, so the master clock is divided by 4, 8, 16 and 32.
- R2: A change of `div_sel` takes effect only at the next rising edge of `pdm_clk`. The period already in progress finishes with its old half lengths, so no shortened pulse appears.
- R3: Channels 1 and 2 (`samp_bits[0]`, `samp_bits[1]`) take data wire `pdm_din[0]`. Channels 3 and 4 (`samp_bits[2]`, `samp_bits[3]`) take `pdm_din[1]`.
- R4: When `edge_sel[i]` is 0, channel i takes its wire's value in the last master cycle of the high half. When it is 1, channel i takes the value in the last master cycle of the low half.
- R5: `samp_valid` pulses for exactly one master cycle, in the first cycle of each new bit-clock period. `samp_bits` changes only in that cycle and holds otherwise.
- R6: For channel 1, `src_sel[1:0]` selects the source; for channel 2, `src_sel[3:2]` does. Code 2'b10 selects the digital wire. Any other code selects analog, and the channel bit is then `ana_bit[i]` as seen in the last master cycle of the low half.
- R7: `ana_pwrdn[i]` is 1 exactly when channel i's source code is 2'b10. It follows the code one master cycle later.
- R8: While `rst_n` is low, `pdm_clk`, `samp_valid`, `samp_bits` and `ana_pwrdn` are all 0. The first master edge after release starts the first high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Bit-clock divider code |
| edge_sel | input | 4 | Latch half per channel (0 = high half, 1 = low half) |
| src_sel | input | 4 | Source codes for channels 1 and 2 |
| pdm_din | input | 2 | Shared PDM data wires |
| ana_bit | input | 2 | Placeholder analog bits for channels 1 and 2 |
| pdm_clk | output | 1 | PDM bit clock to the microphones |
| samp_bits | output | 4 | Captured channel bits |
| samp_valid | output | 1 | One-cycle strobe per bit-clock period |
| ana_pwrdn | output | 2 | Analog power-down flags for channels 1 and 2 |

## Verification
All four divider codes are swept against all sixteen latch-edge patterns. Each data wire carries fresh random bits every master cycle, so a channel that latches in the wrong cycle or the wrong half, or reads the wrong wire, produces a different value from the expected one. A sweep over every pair of source codes separates the digital path from the analog placeholder and checks the power-down flags. Divider changes written at random phases check that the running period keeps its shape, and a reset in mid-run shows that the outputs clear and the clock restarts cleanly.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

    localparam int PDM_SEL_W     = 2;
    localparam int PDM_BASE_HALF = 2;
    localparam int PDM_MAX_HALF  = PDM_BASE_HALF << ((1 << PDM_SEL_W) - 1);
    localparam int PDM_CNT_W     = $clog2(PDM_MAX_HALF);
    localparam int NUM_LINE      = 2;
    localparam int CH_PER_LINE   = 2;
    localparam int NUM_CH        = NUM_LINE * CH_PER_LINE;
    localparam int NUM_ANA       = 2;
    localparam int SRC_W         = 2;

    localparam logic [SRC_W-1:0] SRC_DIGITAL = 2'b10;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_HIGH = 2'd1,
        GEN_LOW  = 2'd2
    } gen_state_e;

    // last count of a half period for a divider code
    function automatic logic [PDM_CNT_W-1:0] last_idx(input logic [PDM_SEL_W-1:0] sel);
        logic [PDM_CNT_W:0] half;
        half = (PDM_CNT_W+1)'(PDM_BASE_HALF) << sel;
        return PDM_CNT_W'(half - (PDM_CNT_W+1)'(1));
    endfunction

endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
    import pdm_cap_pkg::*;
(
    input  logic                 mclk,
    input  logic                 rst_n,
    input  logic [PDM_SEL_W-1:0] div_sel,
    output logic                 pdm_clk,
    output logic                 tap_rise,
    output logic                 tap_fall
);

    gen_state_e             state_q, state_n;
    logic [PDM_CNT_W-1:0]   cnt_q, cnt_n;
    logic [PDM_SEL_W-1:0]   act_q, act_n;
    logic                   clk_q;
    logic                   half_done;

    assign half_done = (cnt_q == last_idx(act_q));

    // next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q + PDM_CNT_W'(1);
        act_n   = act_q;
        unique case (state_q)
            GEN_IDLE: begin
                state_n = GEN_HIGH;
                cnt_n   = '0;
                act_n   = div_sel;
            end
            GEN_HIGH: begin
                if (half_done) begin
                    state_n = GEN_LOW;
                    cnt_n   = '0;
                end
            end
            GEN_LOW: begin
                if (half_done) begin
                    state_n = GEN_HIGH;
                    cnt_n   = '0;
                    act_n   = div_sel;
                end
            end
            default: begin
                state_n = GEN_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            act_q   <= act_n;
        end
    end

    // outputs
    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) clk_q <= 1'b0;
        else        clk_q <= (state_n == GEN_HIGH);
    end

    always_comb begin
        pdm_clk  = clk_q;
        tap_rise = (state_q == GEN_HIGH) && half_done;
        tap_fall = (state_q == GEN_LOW)  && half_done;
    end

    p_rise_in_high_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        tap_rise |-> pdm_clk);

    p_fall_in_low_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        tap_fall |-> !pdm_clk);

    p_cnt_range_r1: assert property (@(posedge mclk) disable iff (!rst_n)
        cnt_q <= last_idx(act_q));

    p_div_at_boundary_r2: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(act_q) |-> ($past(tap_fall) || $past(state_q == GEN_IDLE)));

endmodule

// File: rtl/pdm_edge_lane.sv
module pdm_edge_lane (
    input  logic mclk,
    input  logic rst_n,
    input  logic tap_rise,
    input  logic tap_fall,
    input  logic fall_edge,
    input  logic din,
    output logic cap_bit
);

    logic hold_q;

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n)                                hold_q <= 1'b0;
        else if (fall_edge ? tap_fall : tap_rise)  hold_q <= din;
    end

    // a low-half channel is taken live at the collection tap
    assign cap_bit = fall_edge ? din : hold_q;

    p_hold_on_tap_r4: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(hold_q) |-> $past(tap_rise || tap_fall));

endmodule

// File: rtl/pdm_src_mux.sv
module pdm_src_mux
    import pdm_cap_pkg::*;
(
    input  logic             mclk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_code,
    input  logic             dig_bit,
    input  logic             ana_bit,
    output logic             bit_out,
    output logic             pwrdn
);

    logic use_dig;
    logic pwr_q;

    assign use_dig = (src_code == SRC_DIGITAL);
    assign bit_out = use_dig ? dig_bit : ana_bit;

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) pwr_q <= 1'b0;
        else        pwr_q <= use_dig;
    end

    assign pwrdn = pwr_q;

    p_pwrdn_follow_r7: assert property (@(posedge mclk) disable iff (!rst_n)
        $past(rst_n) |-> (pwrdn == $past(src_code == SRC_DIGITAL)));

endmodule

// File: rtl/pdm_mic_capture.sv
module pdm_mic_capture
    import pdm_cap_pkg::*;
(
    input  logic                     mclk,
    input  logic                     rst_n,
    input  logic [PDM_SEL_W-1:0]     div_sel,
    input  logic [NUM_CH-1:0]        edge_sel,
    input  logic [NUM_ANA*SRC_W-1:0] src_sel,
    input  logic [NUM_LINE-1:0]      pdm_din,
    input  logic [NUM_ANA-1:0]       ana_bit,
    output logic                     pdm_clk,
    output logic [NUM_CH-1:0]        samp_bits,
    output logic                     samp_valid,
    output logic [NUM_ANA-1:0]       ana_pwrdn
);

    logic              tap_rise, tap_fall;
    logic [NUM_CH-1:0] lane_bit;
    logic [NUM_CH-1:0] pick_bit;
    logic [NUM_CH-1:0] bits_q;
    logic              valid_q;

    pdm_clkgen u_clkgen (
        .mclk     (mclk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .pdm_clk  (pdm_clk),
        .tap_rise (tap_rise),
        .tap_fall (tap_fall)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        pdm_edge_lane u_lane (
            .mclk      (mclk),
            .rst_n     (rst_n),
            .tap_rise  (tap_rise),
            .tap_fall  (tap_fall),
            .fall_edge (edge_sel[ch]),
            .din       (pdm_din[ch / CH_PER_LINE]),
            .cap_bit   (lane_bit[ch])
        );

        if (ch < NUM_ANA) begin : g_sel
            pdm_src_mux u_mux (
                .mclk     (mclk),
                .rst_n    (rst_n),
                .src_code (src_sel[ch*SRC_W +: SRC_W]),
                .dig_bit  (lane_bit[ch]),
                .ana_bit  (ana_bit[ch]),
                .bit_out  (pick_bit[ch]),
                .pwrdn    (ana_pwrdn[ch])
            );
        end else begin : g_dig
            assign pick_bit[ch] = lane_bit[ch];
        end
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= tap_fall;
            if (tap_fall) bits_q <= pick_bit;
        end
    end

    assign samp_bits  = bits_q;
    assign samp_valid = valid_q;

    p_valid_single_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        samp_valid |=> !samp_valid);

    p_bits_hold_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        !$stable(samp_bits) |-> samp_valid);

    p_valid_in_high_r5: assert property (@(posedge mclk) disable iff (!rst_n)
        samp_valid |-> pdm_clk);

endmodule

// File: tb/test_pdm_mic_capture.sv
module test_pdm_mic_capture;

    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] div_sel = '0;
    logic [3:0] edge_sel = '0;
    logic [3:0] src_sel = '0;
    logic [1:0] pdm_din = '0;
    logic [1:0] ana_bit = '0;
    logic       pdm_clk;
    logic [3:0] samp_bits;
    logic       samp_valid;
    logic [1:0] ana_pwrdn;

    always #4 mclk = ~mclk;

    pdm_mic_capture i_pdm_mic_capture (
        .mclk       (mclk),
        .rst_n      (rst_n),
        .div_sel    (div_sel),
        .edge_sel   (edge_sel),
        .src_sel    (src_sel),
        .pdm_din    (pdm_din),
        .ana_bit    (ana_bit),
        .pdm_clk    (pdm_clk),
        .samp_bits  (samp_bits),
        .samp_valid (samp_valid),
        .ana_pwrdn  (ana_pwrdn)
    );

    int total = 0;
    int bad   = 0;

    // bench model of the bit-clock timeline
    int         m_ph = 0;
    int         m_half = 2;
    bit         m_first = 1'b1;
    bit         m_have = 1'b0;
    bit         r2_pend = 1'b0;
    logic [1:0] m_rise = '0;
    logic [3:0] m_exp = '0;
    logic [3:0] last_bits = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        string tag;
        logic [1:0] nd, na;
        @(negedge mclk);
        tag = r2_pend ? "R2" : "R1";
        if (m_first) begin
            m_half  = 2 << div_sel;
            m_ph    = 0;
            m_first = 1'b0;
            tag     = "R8";
        end else if (m_ph == 2*m_half - 1) begin
            m_ph    = 0;
            m_half  = 2 << div_sel;
        end else begin
            m_ph++;
        end
        chk(pdm_clk == (m_ph < m_half), tag, "pdm_clk", pdm_clk, int'(m_ph < m_half));
        if (m_ph == 0) r2_pend = 1'b0;

        chk(samp_valid == (m_ph == 0 && m_have), "R5", "samp_valid",
            samp_valid, int'(m_ph == 0 && m_have));
        if (m_ph == 0 && m_have) begin
            for (int i = 0; i < 4; i++) begin
                if (i < 2 && src_sel[2*i +: 2] != 2'b10)
                    chk(samp_bits[i] == m_exp[i], "R6", $sformatf("analog ch%0d", i+1),
                        samp_bits[i], m_exp[i]);
                else
                    chk(samp_bits[i] == m_exp[i], "R3/R4", $sformatf("digital ch%0d", i+1),
                        samp_bits[i], m_exp[i]);
            end
            last_bits = m_exp;
        end else begin
            chk(samp_bits == last_bits, "R5", "bits hold", samp_bits, last_bits);
        end
        if (m_ph == 0) begin
            chk(ana_pwrdn[0] == (src_sel[1:0] == 2'b10), "R7", "pwrdn ch1",
                ana_pwrdn[0], int'(src_sel[1:0] == 2'b10));
            chk(ana_pwrdn[1] == (src_sel[3:2] == 2'b10), "R7", "pwrdn ch2",
                ana_pwrdn[1], int'(src_sel[3:2] == 2'b10));
        end

        nd = 2'($urandom);
        na = 2'($urandom);
        pdm_din = nd;
        ana_bit = na;
        if (m_ph == m_half - 1) m_rise = nd;
        if (m_ph == 2*m_half - 1) begin
            for (int i = 0; i < 4; i++) begin
                m_exp[i] = edge_sel[i] ? nd[i/2] : m_rise[i/2];
                if (i < 2 && src_sel[2*i +: 2] != 2'b10) m_exp[i] = na[i];
            end
            m_have = 1'b1;
        end
    endtask

    task automatic at_boundary();
        do step(); while (m_ph != 0);
    endtask

    task automatic run_periods(input int n);
        repeat (n) at_boundary();
    endtask

    task automatic do_reset();
        @(negedge mclk);
        rst_n = 1'b0;
        repeat (2) @(negedge mclk);
        chk(pdm_clk == 1'b0, "R8", "pdm_clk in reset", pdm_clk, 0);
        chk(samp_valid == 1'b0, "R8", "valid in reset", samp_valid, 0);
        chk(samp_bits == 4'h0, "R8", "bits in reset", samp_bits, 0);
        chk(ana_pwrdn == 2'b00, "R8", "pwrdn in reset", ana_pwrdn, 0);
        m_first   = 1'b1;
        m_have    = 1'b0;
        r2_pend   = 1'b0;
        last_bits = '0;
        rst_n     = 1'b1;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge mclk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        summary();
        $finish;
    end

    initial begin
        do_reset();
        run_periods(2);

        // divider x edge sweep
        for (int d = 0; d < 4; d++) begin
            for (int e = 0; e < 16; e++) begin
                at_boundary();
                div_sel  = 2'(d);
                edge_sel = 4'(e);
                src_sel  = 4'(e * 5);
                run_periods(3);
            end
        end

        // source code sweep
        div_sel = 2'd0;
        for (int s = 0; s < 16; s++) begin
            at_boundary();
            src_sel  = 4'(s);
            edge_sel = 4'(15 - s);
            run_periods(2);
        end

        // divider changes at random phases
        src_sel  = 4'b1010;
        edge_sel = 4'b0110;
        for (int k = 0; k < 24; k++) begin
            repeat ($urandom_range(1, 40)) step();
            div_sel = 2'($urandom);
            r2_pend = 1'b1;
        end
        run_periods(3);

        // reset in mid-run
        repeat (7) step();
        do_reset();
        run_periods(3);

        summary();
        $finish;
    end

endmodule